// File: doc/BRIEF.md
# Three-Axis Sample Output Registers with Pair-Coherent Update

This block holds the most recent three-axis acceleration sample as six byte registers that a host reads one at a time over a simple register bus. Each new-sample strobe brings three 14-bit values. The block stores each one as a left-aligned 16-bit two's complement word. A resolution flag picks between keeping all 14 bits and keeping only the top 12 bits.

The block keeps a sticky ready flag for the host and drives a ready line toward an interrupt pin. The line can either follow the flag or give a fixed-length pulse for each sample. The pulse length is a cycle count, with separate values for the high-performance and low-power settings.

When pair-coherent update is on, the host may start reading an axis at either byte. That axis is then frozen until the host has read its other byte, so both halves always come from one sample. The other axes keep updating in the meantime. A sample that arrives while an axis is frozen is kept in a shadow word and loaded when the pair is released.

Top module: `accel_out_regs`

## Requirements
- R1: Read index 0/1 returns the X low/high byte, 2/3 the Y low/high byte and 4/5 the Z low/high byte. Indexes 6 and 7 return 0x00 and have no side effect. `rd_data` is combinational from the index.
- R2: With `res_hi`=1 a sample v is stored as {v,2'b00}. With `res_hi`=0 it is stored as {v[13:2],4'b0000}.
- R3: `status_rdy` is 1 in the cycle after a `smp_valid` strobe.
- R4: A read of index 1, 3 or 5 clears `status_rdy` at that clock edge. Reads of low bytes leave it set. A strobe in the same cycle as such a read keeps it set.
- R5: With `pulse_mode`=0, `drdy_pin` equals `status_rdy`.
- R6: With `pulse_mode`=1, `drdy_pin` is high for exactly PULSE_HP cycles (`hp_mode`=1) or PULSE_LP cycles (`hp_mode`=0), starting in the cycle after the strobe. `status_rdy` still behaves as in R3 and R4.
- R7: With `bdu_en`=0, every strobe refreshes all three axes, whatever bytes have been read.
- R8: With `bdu_en`=1, reading one byte of an axis freezes that axis until its other byte is read. Axes that are not being read keep updating.
- R9: The newest sample that arrived while an axis was frozen becomes visible once the pair is released. If a strobe coincides with the releasing read, that strobe's sample is the one loaded.
- R10: Reading the same byte of a frozen axis again does not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | New-sample strobe, one cycle |
| smp_x | input | 14 | X sample |
| smp_y | input | 14 | Y sample |
| smp_z | input | 14 | Z sample |
| res_hi | input | 1 | 1: 14-bit storage, 0: 12-bit storage |
| bdu_en | input | 1 | Pair-coherent update enable |
| pulse_mode | input | 1 | 1: pulsed ready line, 0: line follows the flag |
| hp_mode | input | 1 | Selects the high-performance pulse length |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 3 | Byte read index |
| rd_data | output | 8 | Read data for `rd_addr` |
| status_rdy | output | 1 | Sticky new-data flag |
| drdy_pin | output | 1 | Ready line toward the interrupt pin |

## Verification
The bench interleaves strobes with partial axis reads.
- If the freeze is released by a repeated read of the same byte, the high byte returned would come from a newer sample than the low byte.
- If the shadow is dropped at release, the next read would return a stale value.
- The bench places a strobe on the releasing read and on a high-byte read. A wrong priority there either loses the newer sample or clears the flag that the strobe just set.
- The bench measures the pulse length in both pulse settings. An off-by-one counter would give a width one cycle too long or too short.

// File: rtl/accel_out_pkg.sv
package accel_out_pkg;
    localparam int WORD_W = 16;
    localparam int N_AXES = 3;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] shadow;
        logic              pend;
        logic              seen_lo;
        logic              seen_hi;
    } slot_state_t;
endpackage

// File: rtl/accel_axis_slot.sv
module accel_axis_slot
    import accel_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bdu_en,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_word,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [WORD_W-1:0] out_word,
    output logic              held
);
    slot_state_t st_d, st_q;

    always_comb begin
        logic lo_seen;
        logic hi_seen;
        st_d    = st_q;
        lo_seen = st_q.seen_lo | rd_lo;
        hi_seen = st_q.seen_hi | rd_hi;
        if (!bdu_en) begin
            st_d.seen_lo = 1'b0;
            st_d.seen_hi = 1'b0;
            st_d.pend    = 1'b0;
            if (smp_valid)      st_d.word = smp_word;
            else if (st_q.pend) st_d.word = st_q.shadow;
        end else if (lo_seen && hi_seen) begin
            st_d.seen_lo = 1'b0;
            st_d.seen_hi = 1'b0;
            st_d.pend    = 1'b0;
            if (smp_valid)      st_d.word = smp_word;
            else if (st_q.pend) st_d.word = st_q.shadow;
        end else if (lo_seen || hi_seen) begin
            st_d.seen_lo = lo_seen;
            st_d.seen_hi = hi_seen;
            if (smp_valid) begin
                st_d.shadow = smp_word;
                st_d.pend   = 1'b1;
            end
        end else if (smp_valid) begin
            st_d.word = smp_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_word = st_q.word;
    assign held     = st_q.seen_lo | st_q.seen_hi;
endmodule

// File: rtl/accel_drdy_gen.sv
module accel_drdy_gen #(
    parameter int PULSE_HP = 3750,
    parameter int PULSE_LP = 7000,
    localparam int PMAX  = (PULSE_HP > PULSE_LP) ? PULSE_HP : PULSE_LP,
    localparam int CNT_W = $clog2(PMAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic rd_hi_any,
    input  logic pulse_mode,
    input  logic hp_mode,
    output logic status_rdy,
    output logic drdy_pin
);
    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } drdy_state_t;

    drdy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_valid)      st_d.flag = 1'b1;
        else if (rd_hi_any) st_d.flag = 1'b0;
        if (smp_valid)
            st_d.cnt = hp_mode ? CNT_W'(PULSE_HP) : CNT_W'(PULSE_LP);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_rdy = st_q.flag;
    assign drdy_pin   = pulse_mode ? (st_q.cnt != '0) : st_q.flag;
endmodule

// File: rtl/accel_out_regs.sv
module accel_out_regs
    import accel_out_pkg::*;
#(
    parameter int AXIS_W   = 14,
    parameter int LO_RES_W = 12,
    parameter int PULSE_HP = 3750,
    parameter int PULSE_LP = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [AXIS_W-1:0] smp_x,
    input  logic [AXIS_W-1:0] smp_y,
    input  logic [AXIS_W-1:0] smp_z,
    input  logic              res_hi,
    input  logic              bdu_en,
    input  logic              pulse_mode,
    input  logic              hp_mode,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              status_rdy,
    output logic              drdy_pin
);
    localparam int PAD_W = WORD_W - AXIS_W;
    localparam logic [WORD_W-1:0] LO_MASK = ~((WORD_W'(1) << (WORD_W - LO_RES_W)) - WORD_W'(1));

    logic [N_AXES-1:0][AXIS_W-1:0] smp_in;
    logic [N_AXES-1:0][WORD_W-1:0] axis_word;
    logic [N_AXES-1:0]             axis_held;
    logic                          rd_hi_any;

    assign smp_in = {smp_z, smp_y, smp_x};

    for (genvar i = 0; i < N_AXES; i++) begin : g_axis
        logic [WORD_W-1:0] fmt_word;
        logic              rd_lo_i;
        logic              rd_hi_i;
        always_comb begin
            fmt_word = {smp_in[i], {PAD_W{1'b0}}};
            if (!res_hi) fmt_word = fmt_word & LO_MASK;
        end
        assign rd_lo_i = rd_en && (rd_addr == 3'(2 * i));
        assign rd_hi_i = rd_en && (rd_addr == 3'(2 * i + 1));
        accel_axis_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .bdu_en   (bdu_en),
            .smp_valid(smp_valid),
            .smp_word (fmt_word),
            .rd_lo    (rd_lo_i),
            .rd_hi    (rd_hi_i),
            .out_word (axis_word[i]),
            .held     (axis_held[i])
        );
    end

    assign rd_hi_any = rd_en && rd_addr[0] && (rd_addr < 3'(2 * N_AXES));

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < N_AXES; k++) begin
            if (rd_addr == 3'(2 * k))     rd_data = axis_word[k][7:0];
            if (rd_addr == 3'(2 * k + 1)) rd_data = axis_word[k][15:8];
        end
    end

    accel_drdy_gen #(
        .PULSE_HP(PULSE_HP),
        .PULSE_LP(PULSE_LP)
    ) u_drdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .rd_hi_any (rd_hi_any),
        .pulse_mode(pulse_mode),
        .hp_mode   (hp_mode),
        .status_rdy(status_rdy),
        .drdy_pin  (drdy_pin)
    );
endmodule

// File: rtl/accel_out_regs_chk.sv
module accel_out_regs_chk
    import accel_out_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          smp_valid,
    input logic                          rd_en,
    input logic [2:0]                    rd_addr,
    input logic                          bdu_en,
    input logic                          pulse_mode,
    input logic                          status_rdy,
    input logic                          drdy_pin,
    input logic [N_AXES-1:0]             axis_held,
    input logic [N_AXES-1:0][WORD_W-1:0] axis_word
);
    logic hi_read;
    assign hi_read = rd_en && rd_addr[0] && (rd_addr < 3'd6);

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> status_rdy);

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rdy && !hi_read) |=> status_rdy);

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_read && !smp_valid) |=> !status_rdy);

    assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && pulse_mode) |=> (drdy_pin || !pulse_mode));

    assert_line_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && !status_rdy) |-> !drdy_pin);

    for (genvar i = 0; i < N_AXES; i++) begin : g_hold
        assert_pair_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bdu_en && axis_held[i] && !(rd_en && rd_addr[2:1] == 2'(i)))
            |=> $stable(axis_word[i]));
    end
endmodule

bind accel_out_regs accel_out_regs_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .bdu_en    (bdu_en),
    .pulse_mode(pulse_mode),
    .status_rdy(status_rdy),
    .drdy_pin  (drdy_pin),
    .axis_held (axis_held),
    .axis_word (axis_word)
);

// File: tb/test_accel_out_regs.sv
module test_accel_out_regs;
    localparam int PHP = 6;
    localparam int PLP = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [13:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic res_hi = 1'b1, bdu_en = 1'b0, pulse_mode = 1'b0, hp_mode = 1'b1;
    logic rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic status_rdy, drdy_pin;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    accel_out_regs #(.PULSE_HP(PHP), .PULSE_LP(PLP)) i_accel_out_regs (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .res_hi(res_hi),
        .bdu_en(bdu_en), .pulse_mode(pulse_mode), .hp_mode(hp_mode),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .status_rdy(status_rdy), .drdy_pin(drdy_pin)
    );

    // table entry: {res_hi, x, y, z}
    localparam logic [42:0] VEC [5] = '{
        {1'b1, 14'h3F58, 14'h001E, 14'h10BF},
        {1'b0, 14'h2A5B, 14'h1234, 14'h3FFF},
        {1'b1, 14'h0001, 14'h2000, 14'h1FFF},
        {1'b0, 14'h0ACE, 14'h3003, 14'h0777},
        {1'b1, 14'h3FFF, 14'h0F0F, 14'h2AAA}
    };

    function automatic logic [15:0] fmt(input logic [13:0] v, input logic hi);
        return hi ? {v, 2'b00} : {v[13:2], 4'b0000};
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [13:0] x, input logic [13:0] y, input logic [13:0] z);
        @(negedge clk);
        smp_x = x; smp_y = y; smp_z = z; smp_valid = 1'b1;
        @(posedge clk); #1 smp_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    // read with a strobe in the same cycle
    task automatic rd_strobe(input logic [2:0] a, input logic [13:0] s, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        smp_x = s; smp_y = s; smp_z = s; smp_valid = 1'b1;
        #1 v = rd_data;
        @(posedge clk); #1 begin rd_en = 1'b0; smp_valid = 1'b0; end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] b;
        logic [15:0] e;
        int w;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(16'(status_rdy), 16'd0, "R3 reset flag");
        chk(16'(drdy_pin), 16'd0, "R5 reset line");
        rd(3'd0, b); chk(16'(b), 16'h00, "R1 reset data");

        // table walk, bdu off, latched line
        for (int i = 0; i < 5; i++) begin
            logic [13:0] vx, vy, vz;
            logic vh;
            {vh, vx, vy, vz} = VEC[i];
            res_hi = vh;
            strobe(vx, vy, vz);
            chk(16'(status_rdy), 16'd1, "R3 flag after strobe");
            chk(16'(drdy_pin), 16'(status_rdy), "R5 line follows flag");
            rd(3'd0, b); chk(16'(b), 16'(fmt(vx, vh) & 16'h00FF), "R1 R2 x lo");
            chk(16'(status_rdy), 16'd1, "R4 lo read keeps flag");
            rd(3'd1, b); chk(16'(b), 16'(fmt(vx, vh) >> 8), "R1 R2 x hi");
            chk(16'(status_rdy), 16'd0, "R4 hi read clears flag");
            chk(16'(drdy_pin), 16'd0, "R5 line cleared");
            rd(3'd2, b); chk(16'(b), 16'(fmt(vy, vh) & 16'h00FF), "R1 R2 y lo");
            rd(3'd3, b); chk(16'(b), 16'(fmt(vy, vh) >> 8), "R1 R2 y hi");
            rd(3'd4, b); chk(16'(b), 16'(fmt(vz, vh) & 16'h00FF), "R1 R2 z lo");
            rd(3'd5, b); chk(16'(b), 16'(fmt(vz, vh) >> 8), "R1 R2 z hi");
            rd(3'd6, b); chk(16'(b), 16'h00, "R1 index 6");
            rd(3'd7, b); chk(16'(b), 16'h00, "R1 index 7");
        end
        res_hi = 1'b1;

        // R4: strobe coincides with hi read
        rd_strobe(3'd3, 14'h0100, b);
        chk(16'(status_rdy), 16'd1, "R4 strobe beats clear");

        // R7: bdu off, refresh between halves
        strobe(14'h1111, 14'h1111, 14'h1111);
        rd(3'd0, b);
        strobe(14'h2222, 14'h2222, 14'h2222);
        rd(3'd1, b); chk(16'(b), 16'(fmt(14'h2222, 1'b1) >> 8), "R7 refresh ignores reads");

        // R8/R9/R10 with bdu on
        bdu_en = 1'b1;
        strobe(14'h0A11, 14'h0A11, 14'h0A11);           // A
        rd(3'd0, b); chk(16'(b), 16'(fmt(14'h0A11, 1'b1) & 16'h00FF), "R8 x lo of A");
        strobe(14'h3B22, 14'h3B22, 14'h3B22);           // B
        rd(3'd3, b); chk(16'(b), 16'(fmt(14'h3B22, 1'b1) >> 8), "R8 y keeps updating");
        rd(3'd2, b); chk(16'(b), 16'(fmt(14'h3B22, 1'b1) & 16'h00FF), "R8 y lo of B");
        rd(3'd1, b); chk(16'(b), 16'(fmt(14'h0A11, 1'b1) >> 8), "R8 x hi frozen at A");
        rd(3'd0, b); chk(16'(b), 16'(fmt(14'h3B22, 1'b1) & 16'h00FF), "R9 shadow loaded");
        rd(3'd0, b); chk(16'(b), 16'(fmt(14'h3B22, 1'b1) & 16'h00FF), "R10 repeat read");
        strobe(14'h05C3, 14'h05C3, 14'h05C3);           // C
        rd(3'd0, b); chk(16'(b), 16'(fmt(14'h3B22, 1'b1) & 16'h00FF), "R10 still frozen");
        rd(3'd1, b); chk(16'(b), 16'(fmt(14'h3B22, 1'b1) >> 8), "R10 hi of B");
        rd(3'd1, b); chk(16'(b), 16'(fmt(14'h05C3, 1'b1) >> 8), "R9 released to C");
        rd(3'd0, b); chk(16'(b), 16'(fmt(14'h05C3, 1'b1) & 16'h00FF), "R8 pair from C");
        // release with coincident strobe
        rd(3'd4, b); chk(16'(b), 16'(fmt(14'h05C3, 1'b1) & 16'h00FF), "R8 z lo of C");
        strobe(14'h1D44, 14'h1D44, 14'h1D44);           // D
        rd_strobe(3'd5, 14'h2E55, b);                   // E
        chk(16'(b), 16'(fmt(14'h05C3, 1'b1) >> 8), "R8 z hi of C");
        rd(3'd4, b); chk(16'(b), 16'(fmt(14'h2E55, 1'b1) & 16'h00FF), "R9 release takes E lo");
        rd(3'd5, b); chk(16'(b), 16'(fmt(14'h2E55, 1'b1) >> 8), "R9 release takes E hi");
        bdu_en = 1'b0;

        // R6: pulse widths
        pulse_mode = 1'b1;
        for (int m = 0; m < 2; m++) begin
            hp_mode = (m == 0);
            strobe(14'h0001, 14'h0001, 14'h0001);
            w = 0;
            @(negedge clk);
            while (drdy_pin && w < 100) begin
                w++;
                @(negedge clk);
            end
            e = 16'(hp_mode ? PHP : PLP);
            chk(16'(w), e, "R6 pulse width");
            chk(16'(status_rdy), 16'd1, "R6 flag stays latched");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule